// File: doc/BRIEF.md
# Per-Pin Power-of-Two Debounce Filter

This block cleans up one general-purpose input pin. The raw pin level is first brought into the clock domain through a short synchronizer chain. It is then passed to a hold filter that counts pulses of a shared one-millisecond tick. The filtered output takes on a new level only after the synchronized input has stayed at that level for 2^N tick periods. N is a three-bit exponent, so the hold period is selectable from 1 ms to 128 ms. A single enable bit turns the filter on. With the enable low, the synchronized level is copied to the output on every clock, and no ticks are needed.

Software chooses N by rounding a requested debounce time to the nearest power of two. The bit just below the leading one of the request decides whether to round up or down. The block itself sees only the resulting exponent and the enable. It counts tick pulses, not clock cycles. Because the first tick can arrive anywhere inside a millisecond, the real hold time falls between 2^N − 1 and 2^N ms.

Top module: `pin_debounce_filter`

## Requirements
- R1: With `dbnc_en` low, a level on `raw_in` appears on `filt_out` exactly three clock edges after it was applied (two synchronizer stages, then the output register), and no tick is needed.
- R2: With `dbnc_en` high and exponent N (0 to 7), `filt_out` takes a new level on the clock edge that carries the 2^N-th tick pulse counted while the synchronized input differs from `filt_out`. It does not change before that tick.
- R3: Tick pulses add up across any idle clock cycles between them, as long as the input level and the exponent stay unchanged.
- R4: If the synchronized input goes back to the current `filt_out` level before the period completes, the output does not change. The partial count is discarded, so a later attempt needs a full 2^N ticks again.
- R5: Any change of `dbnc_exp` discards a running count, and counting restarts from zero under the new exponent.
- R6: While `rst_n` is low (synchronous, active low), `filt_out` loads the synchronized input level on every clock, and the hold count is zero.
- R7: `filt_out` changes only to the current synchronized input level, and only on a cycle where the filter is disabled or a tick pulse is present.
- R8: Tick pulses that arrive while the synchronized input already equals `filt_out` are not counted and do not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-clock pulse, once per millisecond, shared by all pins |
| raw_in | input | 1 | Asynchronous raw pin level |
| dbnc_en | input | 1 | 1 = filter active, 0 = bypass |
| dbnc_exp | input | 3 | Hold period exponent N; the period is 2^N ticks |
| filt_out | output | 1 | Debounced level |

## Verification
The bench checks both ends of the exponent range. A design that decodes the limit off by one would switch one tick early or late at N = 0, and at N = 7 would either wrap its counter or switch at tick 127 instead of tick 128. A short bounce back to the output level is followed by a fresh attempt. A design that keeps the stale count would switch after only the remaining ticks. The bench changes the exponent partway through a count, because keeping the old count would make the output switch one tick early. It also sends ticks while the input already matches the output, which catches a design that pre-loads the counter. The bypass path is timed edge by edge, so an extra or missing pipeline register shows up.

// File: rtl/pdf_pkg.sv
`timescale 1ns/1ps
// Shared constants for the per-pin debounce filter.
// Assumes the hold period is always a power of two of the tick period.
package pdf_pkg;
    localparam int unsigned PDF_EXP_W       = 3;
    localparam int unsigned PDF_SYNC_STAGES = 2;

    // Counter width needed to hold the largest "last tick" index, 2^(2^EXP_W-1)-1.
    function automatic int unsigned pdf_cnt_width(input int unsigned exp_w);
        return (1 << exp_w) - 1;
    endfunction
endpackage

// File: rtl/pdf_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one asynchronous bit.
// Assumes d is a slow level; the flops carry no reset so the chain keeps
// sampling while the block is held in reset.
module pdf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage variant: one sampling flop.
            always_ff @(posedge clk) chain_q <= d;
        end else begin : g_chain
            // Shift the raw level through the chain.
            always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d};
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pdf_hold_timer.sv
`timescale 1ns/1ps
// Tick counter that decides when a held level has lasted 2^exp_sel ticks.
// Assumes tick is a one-cycle pulse; run must stay high during a hold attempt,
// and restart clears any partial count.
module pdf_hold_timer #(
    parameter int unsigned EXP_W = pdf_pkg::PDF_EXP_W,
    parameter int unsigned CNT_W = pdf_pkg::pdf_cnt_width(EXP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] count_q;

    // Index of the final tick of the period, 2^exp_sel - 1.
    always_comb begin
        span     = {{CNT_W{1'b0}}, 1'b1} << exp_sel;
        span_m1  = span - 1'b1;
        last_idx = span_m1[CNT_W-1:0];
    end

    // Period completes on the last tick of an uninterrupted attempt.
    assign expire = run && tick && !restart && (count_q == last_idx);

    // Count ticks during an attempt; clear when idle, restarted or done.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= expire ? '0 : count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/pin_debounce_filter.sv
`timescale 1ns/1ps
// Debounce filter for one GPIO input, paced by a shared millisecond tick.
// Assumes tick_ms is a one-clock pulse; dbnc_exp selects a 2^N tick hold.
// With dbnc_en low the synchronized level passes through one register.
module pin_debounce_filter #(
    parameter int unsigned EXP_W       = pdf_pkg::PDF_EXP_W,
    parameter int unsigned SYNC_STAGES = pdf_pkg::PDF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             raw_in,
    input  logic             dbnc_en,
    input  logic [EXP_W-1:0] dbnc_exp,
    output logic             filt_out
);
    localparam int unsigned CNT_W = pdf_pkg::pdf_cnt_width(EXP_W);

    logic             sync_q;
    logic             sync_prev_q;
    logic [EXP_W-1:0] exp_q;
    logic             filt_q;
    logic             level_moved;
    logic             rate_moved;
    logic             attempt;
    logic             restart;
    logic             expire;
    logic [CNT_W-1:0] hold_cnt;

    pdf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (raw_in),
        .q   (sync_q)
    );

    // Remember last synchronized level and exponent to spot changes.
    always_ff @(posedge clk) begin
        sync_prev_q <= sync_q;
        exp_q       <= dbnc_exp;
    end

    // An attempt runs while filtering and input differs from output.
    always_comb begin
        level_moved = (sync_q != sync_prev_q);
        rate_moved  = (dbnc_exp != exp_q);
        restart     = level_moved || rate_moved;
        attempt     = dbnc_en && (sync_q != filt_q);
    end

    pdf_hold_timer #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .run     (attempt),
        .restart (restart),
        .exp_sel (dbnc_exp),
        .expire  (expire),
        .count   (hold_cnt)
    );

    // Output register: track input in reset or bypass, else on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !dbnc_en || expire) begin
            filt_q <= sync_q;
        end
    end

    assign filt_out = filt_q;
endmodule

// File: rtl/pdf_checker.sv
`timescale 1ns/1ps
// Property checker for pin_debounce_filter, attached through bind.
// Assumes it observes the synchronized level and the hold count of the top.
module pdf_checker #(
    parameter int unsigned EXP_W = 3,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_ms,
    input logic             dbnc_en,
    input logic [EXP_W-1:0] dbnc_exp,
    input logic             sync_q,
    input logic             filt_out,
    input logic [CNT_W-1:0] hold_cnt
);
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W-1:0] last_idx;

    // Expected last tick index for the present exponent.
    always_comb begin
        span     = {{CNT_W{1'b0}}, 1'b1} << dbnc_exp;
        span_m1  = span - 1'b1;
        last_idx = span_m1[CNT_W-1:0];
    end

    // R1: bypass copies the synchronized level on the next edge.
    a_r1_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !dbnc_en |=> filt_out == $past(sync_q));

    // R2: the count never passes the last tick index of a steady exponent.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(dbnc_exp) |-> hold_cnt <= last_idx);

    // R5: an exponent change leaves a cleared count.
    a_r5_rate_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbnc_exp) |=> hold_cnt == '0);

    // R7: output moves only to the synchronized level, on a tick or in bypass.
    a_r7_move_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_out) |-> (filt_out == $past(sync_q)) && $past(tick_ms || !dbnc_en));

    // R8: no counting while the input matches the output.
    a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q == filt_out) |=> hold_cnt == '0);
endmodule

bind pin_debounce_filter pdf_checker #(.EXP_W(EXP_W), .CNT_W(CNT_W)) i_pdf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_ms  (tick_ms),
    .dbnc_en  (dbnc_en),
    .dbnc_exp (dbnc_exp),
    .sync_q   (sync_q),
    .filt_out (filt_out),
    .hold_cnt (hold_cnt)
);

// File: tb/test_pin_debounce_filter.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, plus directed
// tests for reset behaviour and bypass latency.
module test_pin_debounce_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       raw_in = 1'b0;
    logic       dbnc_en = 1'b0;
    logic [2:0] dbnc_exp = 3'd0;
    logic       filt_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pin_debounce_filter i_pin_debounce_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_ms  (tick_ms),
        .raw_in   (raw_in),
        .dbnc_en  (dbnc_en),
        .dbnc_exp (dbnc_exp),
        .filt_out (filt_out)
    );

    // Vector: {en, exp[2:0], raw, ticks[7:0], expected out, requirement[3:0]}
    localparam int NV = 15;
    localparam logic [17:0] VECS [NV] = '{
        {1'b1, 3'd0, 1'b1, 8'd1,   1'b1, 4'd2},  // R2 shortest period
        {1'b1, 3'd2, 1'b0, 8'd3,   1'b1, 4'd3},  // R3 partial
        {1'b1, 3'd2, 1'b0, 8'd1,   1'b0, 4'd3},  // R3 accumulates to 4
        {1'b1, 3'd3, 1'b1, 8'd7,   1'b0, 4'd2},  // R2 one short of 8
        {1'b1, 3'd3, 1'b0, 8'd0,   1'b0, 4'd4},  // R4 bounce back
        {1'b1, 3'd3, 1'b0, 8'd5,   1'b0, 4'd8},  // R8 ticks while matched
        {1'b1, 3'd3, 1'b1, 8'd7,   1'b0, 4'd4},  // R4 full period needed again
        {1'b1, 3'd3, 1'b1, 8'd1,   1'b1, 4'd4},  // R4 eighth tick
        {1'b1, 3'd1, 1'b0, 8'd1,   1'b1, 4'd5},  // R5 partial
        {1'b1, 3'd2, 1'b0, 8'd3,   1'b1, 4'd5},  // R5 exponent change restarts
        {1'b1, 3'd2, 1'b0, 8'd1,   1'b0, 4'd5},  // R5 completes at 4
        {1'b0, 3'd2, 1'b1, 8'd0,   1'b1, 4'd1},  // R1 bypass
        {1'b0, 3'd7, 1'b0, 8'd0,   1'b0, 4'd1},  // R1 bypass
        {1'b1, 3'd7, 1'b1, 8'd127, 1'b0, 4'd2},  // R2 one short of 128
        {1'b1, 3'd7, 1'b1, 8'd1,   1'b1, 4'd2}   // R2 128th tick
    };

    task automatic check(input string req, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: filt_out=%b expected %b at %0t", req, got, want, $time);
        end
    endtask

    task automatic one_tick();
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // R6: under reset the output loads the synchronized level.
        rst_n  = 1'b0;
        dbnc_en = 1'b1;
        raw_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R6", filt_out, 1'b1);
        raw_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R6", filt_out, 1'b0);
        rst_n = 1'b1;

        // R1: bypass latency of three edges.
        dbnc_en = 1'b0;
        repeat (2) @(negedge clk);
        raw_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", filt_out, 1'b0);
        @(negedge clk);
        check("R1", filt_out, 1'b1);
        raw_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", filt_out, 1'b0);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            dbnc_en  = VECS[v][17];
            dbnc_exp = VECS[v][16:14];
            raw_in   = VECS[v][13];
            repeat (4) @(negedge clk);
            for (int t = 0; t < int'(VECS[v][12:5]); t++) one_tick();
            check($sformatf("R%0d vector %0d", VECS[v][3:0], v), filt_out, VECS[v][4]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule